// File: doc/BRIEF.md
# CAN bit timing generator

This block turns the module clock into CAN bit timing. A 15-bit configuration word sets four fields, each stored as its value minus one: the clock divider for one time quantum, the resynchronization jump width, the phase segment ahead of the sample point and the phase segment after it. A prescaler produces quantum ticks. A segment sequencer walks each bit through one synchronization quantum, then the first phase segment, then the second. It pulses `sample_o` where the receiver should sample the bus and `bit_end_o` where the bit ends.

The sequencer follows the received bus level `rx_i`. After init is released it is idle. The first recessive-to-dominant edge in that state hard-synchronizes the bit. Later edges resynchronize it: an edge after the sync quantum and before the sample point stretches the first segment, and an edge after the sample point cuts the second segment short. Each adjustment is limited to the jump width. Software may change the configuration only while both the init control and the configuration-enable control are high. Init also holds all timing counters in reset.

Top module: `can_bit_timer`

## Requirements
- R1: Reset loads the configuration word 0x0000_2301. Its layout is: divider in bits [5:0], jump width in bits [7:6], first segment in bits [11:8], second segment in bits [14:12]. `rd_data_o` always shows the word, and bits [31:15] read as 0.
- R2: A write stores `wr_data_i[14:0]` only when `wr_en_i`, `init_i` and `cce_i` are all 1 at the clock edge. Any other write leaves the word unchanged.
- R3: One time quantum lasts divider+1 clock cycles, counted from the release of init or from a synchronization event.
- R4: A nominal bit lasts 1 + (first+1) + (second+1) quanta. `sample_o` is high for exactly the last clock of the last first-segment quantum. `bit_end_o` is high for exactly the last clock of the last second-segment quantum. The two never coincide.
- R5: A first-segment field of 0 is timed as if it were 1, so that segment lasts 2 quanta.
- R6: While `init_i` is 1, no strobe is issued and the timing restarts at the sync quantum in the idle state. The first bit begins on the first clock after `init_i` falls.
- R7: In the idle state, a falling edge on `rx_i` restarts the bit. The next clock begins a fresh sync quantum, and the block leaves the idle state.
- R8: Outside the idle state, an edge seen in the quantum at position p of the first segment (p = 1 for its first quantum) lengthens that segment by min(p, jump+1) quanta.
- R9: An edge seen in the second segment with r quanta left in the bit (the current quantum included) works as follows. If r > jump+1, the segment is shortened by jump+1 quanta. Otherwise `bit_end_o` pulses in that same clock and the next clock begins a new sync quantum.
- R10: Only the first edge in a bit is used for resynchronization, and an edge inside the sync quantum is ignored. A hard synchronization also counts as that bit's one edge.
- R11: An edge means `rx_i` was 1 on the previous clock and is 0 now. Before the first clock edge after reset, the previous level is taken as 1. Rising edges have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | 32 | Configuration write data |
| rd_data_o | output | 32 | Configuration word readback |
| init_i | input | 1 | Init control; holds timing in reset |
| cce_i | input | 1 | Configuration-change enable |
| rx_i | input | 1 | Received bus level (1 = recessive) |
| sample_o | output | 1 | Sample-point strobe |
| bit_end_o | output | 1 | Bit-boundary strobe |

## Verification
The assertions check several rules on every cycle. The word holds still under a blocked write, and the prescaler count stays within the divider. A sample strobe always hands over to the second segment, and a bit-end strobe always returns to the sync quantum. Init keeps the sequencer parked and idle, and the first-segment counter never passes its longest stretched length. The exact placement of each strobe after hard synchronization, lengthening, shortening and early bit end, and the clamping of a zero first segment, depend on edge phases against the bit position. Only the bench's cycle model can show these, as it sweeps edge trains of several periods across bits of several shapes.

// File: rtl/cbt_pkg.sv
`timescale 1ns/1ps
package cbt_pkg;
  localparam int BRP_W = 6;
  localparam int SJW_W = 2;
  localparam int TS1_W = 4;
  localparam int TS2_W = 3;
  localparam int CFG_W = BRP_W + SJW_W + TS1_W + TS2_W;
  // quantum counter must hold longest first segment plus max stretch
  localparam int QCW   = TS1_W + 2;

  typedef struct packed {
    logic [TS2_W-1:0] ts2;
    logic [TS1_W-1:0] ts1;
    logic [SJW_W-1:0] sjw;
    logic [BRP_W-1:0] brp;
  } bt_cfg_t;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_TS2  = 2'd2
  } seg_e;
endpackage

// File: rtl/cbt_cfg_reg.sv
`timescale 1ns/1ps
module cbt_cfg_reg import cbt_pkg::*; #(
  parameter int             DW      = 32,
  parameter logic [DW-1:0]  RST_VAL = 'h2301
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          init_i,
  input  logic          cce_i,
  output bt_cfg_t       cfg_o,
  output logic [DW-1:0] rdata_o
);
  localparam int CW = $bits(bt_cfg_t);

  bt_cfg_t cfg_q;
  logic    wr_ok;

  assign wr_ok = we_i & init_i & cce_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cfg_q <= bt_cfg_t'(RST_VAL[CW-1:0]);
    else if (wr_ok) cfg_q <= bt_cfg_t'(wdata_i[CW-1:0]);
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {{(DW-CW){1'b0}}, cfg_q};

  a_r2_locked_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !(init_i && cce_i)) |=> $stable(cfg_q));
  a_r2_open_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> (cfg_q == $past(wdata_i[CW-1:0])));
endmodule

// File: rtl/cbt_prescaler.sv
`timescale 1ns/1ps
module cbt_prescaler #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic         clr_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = !hold_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (hold_i || clr_i)    cnt_q <= '0;
    else if (tick_o)             cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= div_i);
  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/cbt_seg_ctrl.sv
`timescale 1ns/1ps
module cbt_seg_ctrl import cbt_pkg::*; (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    init_i,
  input  logic    tick_i,
  input  logic    fall_i,
  input  bt_cfg_t cfg_i,
  output logic    sample_o,
  output logic    bit_end_o,
  output logic    restart_o
);
  seg_e           seg_q;
  logic [QCW-1:0] qcnt_q, ext_q, shr_q;
  logic           idle_q, rs_done_q;

  logic [QCW-1:0] t1, t2, sjw, ext_new, ext_eff, shr_eff, rem2;
  logic           hard, resync_ok, lengthen, shorten, restart_ts2;
  logic           ts1_last, ts2_last;

  always_comb begin
    // zero first segment clamped to one
    t1 = QCW'((cfg_i.ts1 == '0) ? TS1_W'(1) : cfg_i.ts1) + QCW'(1);
    t2 = QCW'(cfg_i.ts2) + QCW'(1);
    sjw = QCW'(cfg_i.sjw) + QCW'(1);
    ext_new = ((qcnt_q + QCW'(1)) < sjw) ? (qcnt_q + QCW'(1)) : sjw;
    rem2 = t2 - qcnt_q;
    hard = fall_i && idle_q && !init_i;
    resync_ok = fall_i && !idle_q && !rs_done_q && !init_i;
    lengthen = resync_ok && (seg_q == SEG_TS1);
    restart_ts2 = resync_ok && (seg_q == SEG_TS2) && (rem2 <= sjw);
    shorten = resync_ok && (seg_q == SEG_TS2) && (rem2 > sjw);
    ext_eff = lengthen ? ext_new : ext_q;
    shr_eff = shorten ? sjw : shr_q;
    ts1_last = (qcnt_q == (t1 + ext_eff - QCW'(1)));
    ts2_last = (qcnt_q == (t2 - shr_eff - QCW'(1)));
  end

  assign restart_o = hard || restart_ts2;
  assign sample_o  = tick_i && (seg_q == SEG_TS1) && ts1_last && !restart_o;
  assign bit_end_o = (tick_i && (seg_q == SEG_TS2) && ts2_last && !restart_o) || restart_ts2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || init_i) begin
      seg_q     <= SEG_SYNC;
      qcnt_q    <= '0;
      ext_q     <= '0;
      shr_q     <= '0;
      idle_q    <= 1'b1;
      rs_done_q <= 1'b0;
    end else if (restart_o) begin
      seg_q     <= SEG_SYNC;
      qcnt_q    <= '0;
      ext_q     <= '0;
      shr_q     <= '0;
      idle_q    <= 1'b0;
      rs_done_q <= 1'b1;
    end else begin
      if (lengthen) begin
        ext_q     <= ext_new;
        rs_done_q <= 1'b1;
      end
      if (shorten) begin
        shr_q     <= sjw;
        rs_done_q <= 1'b1;
      end
      if (tick_i) begin
        unique case (seg_q)
          SEG_SYNC: begin
            seg_q  <= SEG_TS1;
            qcnt_q <= '0;
          end
          SEG_TS1: begin
            if (ts1_last) begin
              seg_q  <= SEG_TS2;
              qcnt_q <= '0;
            end else qcnt_q <= qcnt_q + QCW'(1);
          end
          SEG_TS2: begin
            if (ts2_last) begin
              seg_q     <= SEG_SYNC;
              qcnt_q    <= '0;
              ext_q     <= '0;
              shr_q     <= '0;
              rs_done_q <= 1'b0;
            end else qcnt_q <= qcnt_q + QCW'(1);
          end
          default: begin
            seg_q  <= SEG_SYNC;
            qcnt_q <= '0;
          end
        endcase
      end
    end
  end

  a_r4_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && bit_end_o));
  a_r4_sample_enters_ts2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && !init_i) |=> (seg_q == SEG_TS2 && qcnt_q == '0));
  a_r4_end_enters_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_end_o |=> (seg_q == SEG_SYNC && qcnt_q == '0));
  a_r6_init_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (seg_q == SEG_SYNC && qcnt_q == '0 && idle_q));
  a_r7_hard_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && idle_q && !init_i) |=> (seg_q == SEG_SYNC && !idle_q && rs_done_q));
  a_r8_ts1_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_q == SEG_TS1) |-> (qcnt_q < (t1 + sjw)));
endmodule

// File: rtl/can_bit_timer.sv
`timescale 1ns/1ps
module can_bit_timer import cbt_pkg::*; #(
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] CFG_RST = 'h0000_2301
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              init_i,
  input  logic              cce_i,
  input  logic              rx_i,
  output logic              sample_o,
  output logic              bit_end_o
);
  bt_cfg_t cfg;
  logic    rx_q, fall, tick, restart;

  cbt_cfg_reg #(.DW(DATA_W), .RST_VAL(CFG_RST)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .wdata_i (wr_data_i),
    .init_i  (init_i),
    .cce_i   (cce_i),
    .cfg_o   (cfg),
    .rdata_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 1'b1;
    else         rx_q <= rx_i;
  end
  assign fall = rx_q & ~rx_i;

  cbt_prescaler #(.W(BRP_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (init_i),
    .clr_i  (restart),
    .div_i  (cfg.brp),
    .tick_o (tick)
  );

  cbt_seg_ctrl u_seg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (init_i),
    .tick_i    (tick),
    .fall_i    (fall),
    .cfg_i     (cfg),
    .sample_o  (sample_o),
    .bit_end_o (bit_end_o),
    .restart_o (restart)
  );

  a_r11_rise_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_i && !rx_q) |-> !restart);
endmodule

// File: tb/can_bit_timer_tb_top.sv
`timescale 1ns/1ps
module can_bit_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        init, cce, rx;
  logic        sample, bit_end;

  always #5 clk = ~clk;

  can_bit_timer dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .init_i    (init),
    .cce_i     (cce),
    .rx_i      (rx),
    .sample_o  (sample),
    .bit_end_o (bit_end)
  );

  int    n_checks = 0;
  int    n_errors = 0;
  string req = "R4";

  // behavioural reference: absolute quantum position within the bit
  int          m_pc, m_pos, m_ext, m_shr;
  bit          m_idle, m_rsd, m_prev_rx;
  logic [14:0] m_cfg;
  int          cnt_s, cnt_b;

  task automatic check(string r, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", r, what, act, exp);
    end
  endtask

  task automatic model_cycle();
    int brp, sjw, t1, t2, rem, ee, se, mn;
    bit fall, tick, hard, ok, in1, in2, len, r2, sh, restart, endb, exp_s, exp_b;
    brp = int'(m_cfg[5:0]);
    sjw = int'(m_cfg[7:6]) + 1;
    t1  = ((m_cfg[11:8] == 4'd0) ? 1 : int'(m_cfg[11:8])) + 1;
    t2  = int'(m_cfg[14:12]) + 1;
    fall = m_prev_rx && !rx;
    tick = !init && (m_pc == brp);
    exp_s = 1'b0; exp_b = 1'b0;
    hard = 0; ok = 0; len = 0; r2 = 0; sh = 0; restart = 0;
    ee = m_ext; se = m_shr;
    if (!init) begin
      hard = fall && m_idle;
      ok   = fall && !m_idle && !m_rsd;
      in1  = (m_pos >= 1) && (m_pos <= t1 + m_ext);
      in2  = m_pos > t1 + m_ext;
      rem  = 1 + t1 + m_ext + t2 - m_pos;
      len  = ok && in1;
      r2   = ok && in2 && (rem <= sjw);
      sh   = ok && in2 && (rem > sjw);
      mn   = (m_pos < sjw) ? m_pos : sjw;
      ee   = len ? mn : m_ext;
      se   = sh ? sjw : m_shr;
      restart = hard || r2;
      exp_s = tick && (m_pos == t1 + ee) && !restart;
      endb  = tick && (m_pos == t1 + ee + t2 - se);
      exp_b = (endb && !restart) || r2;
    end
    check(req, "sample_o", {31'd0, sample}, {31'd0, exp_s});
    check(req, "bit_end_o", {31'd0, bit_end}, {31'd0, exp_b});
    check("R1", "rd_data_o", rd_data, {17'd0, m_cfg});
    if (sample) cnt_s++;
    if (bit_end) cnt_b++;
    // advance as the clock edge would
    if (init) begin
      m_pc = 0; m_pos = 0; m_idle = 1; m_rsd = 0; m_ext = 0; m_shr = 0;
    end else if (restart) begin
      m_pc = 0; m_pos = 0; m_idle = 0; m_rsd = 1; m_ext = 0; m_shr = 0;
    end else begin
      if (len) begin m_ext = ee; m_rsd = 1; end
      if (sh)  begin m_shr = sjw; m_rsd = 1; end
      if (tick) begin
        m_pc = 0;
        if (m_pos == t1 + ee + t2 - se) begin
          m_pos = 0; m_ext = 0; m_shr = 0; m_rsd = 0;
        end else m_pos++;
      end else m_pc++;
    end
    if (wr_en && init && cce) m_cfg = wr_data[14:0];
    m_prev_rx = rx;
  endtask

  task automatic step(int n);
    repeat (n) begin
      #1;
      model_cycle();
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic write_cfg(logic [31:0] v, logic i, logic c);
    init = i; cce = c; wr_en = 1'b1; wr_data = v;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic edge_train(int lo, int hi, int n);
    repeat (n) begin
      rx = 1'b0; step(lo);
      rx = 1'b1; step(hi);
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; wr_en = 1'b0; wr_data = '0; init = 1'b0; cce = 1'b0; rx = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1", "reset word", rd_data, 32'h0000_2301);
    check("R1", "reset sample_o", {31'd0, sample}, 32'd0);
    check("R1", "reset bit_end_o", {31'd0, bit_end}, 32'd0);
    rst_ni = 1'b1;
    m_cfg = 15'h2301; m_pc = 0; m_pos = 0; m_idle = 1; m_rsd = 0;
    m_ext = 0; m_shr = 0; m_prev_rx = 1; cnt_s = 0; cnt_b = 0;

    // R3 R4: default 2-cycle quanta, 8-quantum bit
    req = "R3/R4";
    step(48);
    check("R4", "default sample count", cnt_s, 32'd3);
    check("R4", "default bit_end count", cnt_b, 32'd3);

    // R2: locked and open writes
    req = "R2";
    write_cfg(32'h0000_7FFF, 1'b0, 1'b1);
    check("R2", "write w/o init", rd_data, 32'h0000_2301);
    write_cfg(32'h0000_7FFF, 1'b1, 1'b0);
    check("R2", "write w/o cce", rd_data, 32'h0000_2301);
    write_cfg(32'hFFFF_FFFF, 1'b1, 1'b1);
    check("R1", "reserved bits read zero", rd_data, 32'h0000_7FFF);

    // R6: held in init, no strobes
    req = "R6";
    write_cfg(32'h0000_3540, 1'b1, 1'b1);
    check("R2", "open write", rd_data, 32'h0000_3540);
    init = 1'b1; cce = 1'b0;
    edge_train(2, 3, 3);
    init = 1'b0;

    // R7 R11: hard sync from idle, rising edges inert
    req = "R7/R11";
    step(5);
    rx = 1'b0; step(3);
    rx = 1'b1; step(20);

    // R8 R9 R10: edges sweeping all phases, 11-quantum bit
    req = "R8/R9/R10";
    edge_train(2, 11, 24);
    edge_train(1, 8, 24);
    edge_train(3, 14, 16);

    // R5: zero first segment timed as two quanta
    req = "R5";
    write_cfg(32'h0000_1001, 1'b1, 1'b1);
    init = 1'b1; step(1);
    init = 1'b0; cce = 1'b0;
    cnt_s = 0; cnt_b = 0;
    step(40);
    check("R5", "clamped sample count", cnt_s, 32'd4);
    check("R5", "clamped bit_end count", cnt_b, 32'd4);
    edge_train(2, 7, 12);

    // R3 R8 R9: slow quanta, widest jump
    req = "R3/R8/R9";
    write_cfg(32'h0000_23C4, 1'b1, 1'b1);
    init = 1'b1; step(2);
    init = 1'b0; cce = 1'b0;
    step(30);
    edge_train(3, 40, 10);
    edge_train(7, 29, 10);

    // R6: init mid-bit returns to idle; next edge is a hard sync
    req = "R6/R7";
    init = 1'b1; step(3);
    init = 1'b0; step(17);
    edge_train(4, 33, 4);

    finish_run();
  end
endmodule